// File: doc/BRIEF.md
# Branch Target Buffer

This block keeps a small cache of branches that the compiler hinted as likely taken, together with the address each one jumps to. The fetch stage presents every fetch address on the lookup port. In the same cycle the block answers with a hit flag, a taken prediction and the predicted target. Fetch can then steer to the target on the next edge, so a correctly predicted taken branch costs no bubble cycles. Conditional branches, unconditional jumps and loop-closing branches all use the same path.

When a branch resolves, the execution stage drives the update port with the branch address, its real target, whether it was taken, and the hint bit carried in the instruction. The block compares that outcome with what it would have predicted and raises a mispredict flag in the same cycle. It then changes its contents. A hinted branch that was taken is allocated or refreshed. A hinted branch that was not taken is removed. An unhinted branch leaves the buffer as it was. The storage holds 128 entries, arranged as 32 sets of 4 ways, and uses tree pseudo-LRU replacement.

Top module: `branch_target_buffer`

## Requirements
- R1: After a synchronous active-high reset every entry is invalid, so a lookup misses until an allocating update has been made.
- R2: The lookup result is combinational: `lk_hit`, `lk_taken` and `lk_target` reflect `lk_addr` in the same cycle. `lk_taken` equals `lk_hit`, because only predicted-taken branches are stored.
- R3: The set index is address bits [6:2] (32 sets) and the tag is bits [31:7]. Four branches in one set coexist, entries in different sets do not interfere, and a tag is present at most once per set.
- R4: A hinted, taken update that misses allocates an entry, choosing the lowest-numbered invalid way of the set when one exists. A lookup of that address on any later cycle hits with the new target.
- R5: A hinted, taken update that hits rewrites the target in the matching way and evicts nothing.
- R6: A hinted, not-taken update invalidates the matching entry.
- R7: An update with `upd_hint` low never allocates, rewrites or invalidates an entry.
- R8: When the set is full, allocation evicts the tree pseudo-LRU victim. Both a lookup hit (with `lk_valid` high) and an allocating or rewriting update mark their way as most recent. If both touch the same set in one cycle, the update wins.
- R9: `upd_mispredict` is high in the update cycle when `upd_valid` is high and either of two cases holds. Case one: the buffer's prediction for `upd_addr` (taken on a hit) differs from `upd_taken`. Case two: the branch was taken and hit, but the stored target differs from `upd_target`. It is low otherwise.
- R10: When a hinted update and a valid lookup name the same address (bits [31:2]) in one cycle, the lookup returns the update's outcome: a hit with `upd_target` if taken, a miss if not taken. An unhinted update is not forwarded.
- R11: With `lk_valid` low, `lk_hit` and `lk_taken` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | Lookup found an entry |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | 32 | Predicted target, meaningful when `lk_hit` is high |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Actual target of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_hint | input | 1 | Static predict-taken hint from the instruction |
| upd_mispredict | output | 1 | The buffer's prediction for this branch was wrong |

## Verification
The properties assume that the update port carries at most one resolution per cycle and that its inputs are held at zero while `upd_valid` is low. They also assume `lk_valid` and `upd_valid` are driven to known values from the first clock edge. The persistence checks take for granted that nothing else writes the same address in the cycle after an allocation or invalidation; the forwarding property covers that case separately. The stimulus keeps to these assumptions: every vector drives all inputs together at the falling edge and sets unused fields to zero. Several vectors place a lookup and an update in the same set in one cycle, so that the update-wins rule for replacement state is exercised.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    typedef logic [WAY_W-1:0] way_t;

    // tree state: root picks a half, leaves pick a way inside it; bits point at the victim
    typedef struct packed {
        logic root;
        logic lo;
        logic hi;
    } plru_t;

    typedef struct packed {
        logic hit;
        way_t way;
    } match_t;

    function automatic way_t plru_victim(plru_t s);
        if (!s.root) return {1'b0, s.lo};
        return {1'b1, s.hi};
    endfunction

    function automatic plru_t plru_touch(plru_t s, way_t w);
        plru_t r;
        r      = s;
        r.root = ~w[1];
        if (!w[1]) r.lo = ~w[0];
        else       r.hi = ~w[0];
        return r;
    endfunction

    function automatic way_t first_free(logic [WAYS-1:0] v);
        way_t r;
        r = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!v[w]) r = way_t'(w);
        end
        return r;
    endfunction

endpackage

// File: rtl/btb_way_match.sv
module btb_way_match
    import btb_pkg::*;
#(
    parameter int TAG_W = 25
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            key,
    output logic [WAYS-1:0]             hv,
    output match_t                      res
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hv[w] = vld[w] && (tags[w] == key);
    end

    always_comb begin
        res = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hv[w]) begin
                res.hit = 1'b1;
                res.way = way_t'(w);
            end
        end
    end

endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int SETS  = 32,
    parameter int TAG_W = 25,
    parameter int AW    = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  way_t                        wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [AW-1:0]               wr_tgt,
    input  logic                        inv_en,
    input  logic [IDX_W-1:0]            inv_idx,
    input  way_t                        inv_way,
    input  logic [IDX_W-1:0]            ra_idx,
    output logic [WAYS-1:0]             ra_vld,
    output logic [WAYS-1:0][TAG_W-1:0]  ra_tag,
    output logic [WAYS-1:0][AW-1:0]     ra_tgt,
    input  logic [IDX_W-1:0]            rb_idx,
    output logic [WAYS-1:0]             rb_vld,
    output logic [WAYS-1:0][TAG_W-1:0]  rb_tag,
    output logic [WAYS-1:0][AW-1:0]     rb_tgt
);

    logic [SETS-1:0][WAYS-1:0] vld_q;
    logic [TAG_W-1:0]          tag_q [SETS][WAYS];
    logic [AW-1:0]             tgt_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            if (wr_en)  vld_q[wr_idx][wr_way]   <= 1'b1;
            if (inv_en) vld_q[inv_idx][inv_way] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][wr_way] <= wr_tag;
            tgt_q[wr_idx][wr_way] <= wr_tgt;
        end
    end

    assign ra_vld = vld_q[ra_idx];
    assign rb_vld = vld_q[rb_idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign ra_tag[w] = tag_q[ra_idx][w];
        assign ra_tgt[w] = tgt_q[ra_idx][w];
        assign rb_tag[w] = tag_q[rb_idx][w];
        assign rb_tgt[w] = tgt_q[rb_idx][w];
    end

    // R7: valid bits move only through the write and invalidate ports
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !inv_en) |=> $stable(vld_q));

endmodule

// File: rtl/btb_plru.sv
module btb_plru
    import btb_pkg::*;
#(
    parameter int SETS = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  way_t             wr_way,
    input  logic             lk_en,
    input  logic [IDX_W-1:0] lk_idx,
    input  way_t             lk_way,
    input  logic [IDX_W-1:0] rd_idx,
    output plru_t            rd_state
);

    plru_t st_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) st_q[s] <= '0;
        end else begin
            if (lk_en && !(wr_en && wr_idx == lk_idx))
                st_q[lk_idx] <= plru_touch(st_q[lk_idx], lk_way);
            if (wr_en)
                st_q[wr_idx] <= plru_touch(st_q[wr_idx], wr_way);
        end
    end

    assign rd_state = st_q[rd_idx];

    // R8: after an update touch, the root points away from the written half
    p_touch_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (st_q[$past(wr_idx)].root == !$past(wr_way[1])));

endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
    import btb_pkg::*;
#(
    parameter int AW   = 32,
    parameter int SETS = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lk_valid,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic          lk_taken,
    output logic [AW-1:0] lk_target,
    input  logic          upd_valid,
    input  logic [AW-1:0] upd_addr,
    input  logic [AW-1:0] upd_target,
    input  logic          upd_taken,
    input  logic          upd_hint,
    output logic          upd_mispredict
);

    localparam int OFS   = 2;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = AW - IDX_W - OFS;

    logic [IDX_W-1:0] l_idx, u_idx;
    logic [TAG_W-1:0] l_tag, u_tag;

    assign l_idx = lk_addr[OFS +: IDX_W];
    assign u_idx = upd_addr[OFS +: IDX_W];
    assign l_tag = lk_addr[AW-1 -: TAG_W];
    assign u_tag = upd_addr[AW-1 -: TAG_W];

    logic [WAYS-1:0]            l_vld, u_vld, l_hv, u_hv;
    logic [WAYS-1:0][TAG_W-1:0] l_tags, u_tags;
    logic [WAYS-1:0][AW-1:0]    l_tgts, u_tgts;
    match_t                     l_m, u_m;
    plru_t                      u_plru;

    logic  wr_en, inv_en, alloc_req, fwd_same, pred_taken;
    way_t  wr_way;

    assign alloc_req = upd_valid && upd_hint && upd_taken;
    assign inv_en    = upd_valid && upd_hint && !upd_taken && u_m.hit;
    assign wr_en     = alloc_req;

    always_comb begin
        if (u_m.hit)      wr_way = u_m.way;
        else if (~&u_vld) wr_way = first_free(u_vld);
        else              wr_way = plru_victim(u_plru);
    end

    btb_store #(.SETS(SETS), .TAG_W(TAG_W), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (u_idx),
        .wr_way  (wr_way),
        .wr_tag  (u_tag),
        .wr_tgt  (upd_target),
        .inv_en  (inv_en),
        .inv_idx (u_idx),
        .inv_way (u_m.way),
        .ra_idx  (l_idx),
        .ra_vld  (l_vld),
        .ra_tag  (l_tags),
        .ra_tgt  (l_tgts),
        .rb_idx  (u_idx),
        .rb_vld  (u_vld),
        .rb_tag  (u_tags),
        .rb_tgt  (u_tgts)
    );

    btb_way_match #(.TAG_W(TAG_W)) u_lk_match (
        .vld (l_vld), .tags (l_tags), .key (l_tag), .hv (l_hv), .res (l_m)
    );

    btb_way_match #(.TAG_W(TAG_W)) u_up_match (
        .vld (u_vld), .tags (u_tags), .key (u_tag), .hv (u_hv), .res (u_m)
    );

    btb_plru #(.SETS(SETS)) u_plru_st (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (u_idx),
        .wr_way   (wr_way),
        .lk_en    (lk_valid && l_m.hit),
        .lk_idx   (l_idx),
        .lk_way   (l_m.way),
        .rd_idx   (u_idx),
        .rd_state (u_plru)
    );

    // same-address bypass of a hinted resolution into this cycle's lookup
    assign fwd_same = lk_valid && upd_valid && upd_hint &&
                      (lk_addr[AW-1:OFS] == upd_addr[AW-1:OFS]);

    always_comb begin
        if (fwd_same) begin
            lk_hit    = upd_taken;
            lk_target = upd_target;
        end else begin
            lk_hit    = lk_valid && l_m.hit;
            lk_target = l_tgts[l_m.way];
        end
    end
    assign lk_taken = lk_hit;

    assign pred_taken     = u_m.hit;
    assign upd_mispredict = upd_valid &&
                            ((pred_taken != upd_taken) ||
                             (pred_taken && upd_taken && u_tgts[u_m.way] != upd_target));

    // R3: a tag lives in at most one way of a set
    p_unique_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(l_hv) && $onehot0(u_hv));

    // R1: the first lookup after reset misses unless bypassed
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !fwd_same) |-> !lk_hit);

    // R4/R5: an allocation or rewrite is visible to a lookup on the next cycle
    p_write_visible_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(alloc_req) && lk_valid && !fwd_same &&
         lk_addr[AW-1:OFS] == $past(upd_addr[AW-1:OFS]))
        |-> (lk_hit && lk_target == $past(upd_target)));

    // R6: an invalidated branch misses on the next lookup
    p_inval_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(inv_en) && lk_valid && !fwd_same &&
         lk_addr[AW-1:OFS] == $past(upd_addr[AW-1:OFS]))
        |-> !lk_hit);

    // R10: the bypassed answer matches what the stored state gives one cycle later
    p_fwd_consistent_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(fwd_same) && lk_valid && !upd_valid && lk_addr == $past(lk_addr))
        |-> (lk_hit == $past(lk_hit) && (!lk_hit || lk_target == $past(lk_target))));

endmodule

// File: tb/branch_target_buffer_tb.sv
module branch_target_buffer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_hit, lk_taken;
    logic [31:0] lk_target;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic [31:0] upd_target = '0;
    logic        upd_taken = 1'b0;
    logic        upd_hint = 1'b0;
    logic        upd_mispredict;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    branch_target_buffer u_dut (
        .clk (clk), .rst (rst),
        .lk_valid (lk_valid), .lk_addr (lk_addr),
        .lk_hit (lk_hit), .lk_taken (lk_taken), .lk_target (lk_target),
        .upd_valid (upd_valid), .upd_addr (upd_addr), .upd_target (upd_target),
        .upd_taken (upd_taken), .upd_hint (upd_hint),
        .upd_mispredict (upd_mispredict)
    );

    typedef struct packed {
        logic        lv;
        logic [31:0] la;
        logic        uv;
        logic [31:0] ua;
        logic [31:0] ut;
        logic        tk;
        logic        hn;
        logic        eh;
        logic [31:0] et;
        logic        em;
        logic [7:0]  rq;
    } vec_t;

    // set 0 addresses: tag in [31:7], index [6:2] = 0
    localparam logic [31:0] AD0 = 32'h080, AD1 = 32'h100, AD2 = 32'h180;
    localparam logic [31:0] AD3 = 32'h200, AD4 = 32'h280, AD5 = 32'h300;
    localparam logic [31:0] ADB = 32'h094;  // tag 1, set 5
    localparam logic [31:0] T0 = 32'h4000, T1 = 32'h4100, T2 = 32'h4200;
    localparam logic [31:0] T3 = 32'h4300, T4 = 32'h4400, T1B = 32'h4111;
    localparam logic [31:0] T5 = 32'h4500, TB = 32'h5000;
    localparam logic [31:0] Z = 32'h0;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b1, AD0, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b0, Z,   1'b0, 8'd1 },  // R1 empty
        '{1'b0, Z,   1'b1, AD0, T0,  1'b1, 1'b1, 1'b0, Z,   1'b1, 8'd9 },  // R9 miss+taken
        '{1'b1, AD0, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b1, T0,  1'b0, 8'd4 },  // R4 R2
        '{1'b1, AD1, 1'b1, AD1, T1,  1'b1, 1'b1, 1'b1, T1,  1'b1, 8'd10},  // R10 bypass
        '{1'b0, Z,   1'b1, AD2, T2,  1'b1, 1'b1, 1'b0, Z,   1'b1, 8'd4 },
        '{1'b0, Z,   1'b1, AD3, T3,  1'b1, 1'b1, 1'b0, Z,   1'b1, 8'd4 },
        '{1'b1, AD2, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b1, T2,  1'b0, 8'd3 },  // R3 four coexist
        '{1'b1, AD0, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b1, T0,  1'b0, 8'd8 },  // touch way0
        '{1'b1, AD3, 1'b1, AD4, T4,  1'b1, 1'b1, 1'b1, T3,  1'b1, 8'd8 },  // R8 evicts way3
        '{1'b1, AD3, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b0, Z,   1'b0, 8'd8 },  // R8 victim gone
        '{1'b1, AD1, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b1, T1,  1'b0, 8'd3 },
        '{1'b1, AD4, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b1, T4,  1'b0, 8'd8 },
        '{1'b0, Z,   1'b1, AD1, T1B, 1'b1, 1'b1, 1'b0, Z,   1'b1, 8'd9 },  // R9 wrong target
        '{1'b1, AD1, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b1, T1B, 1'b0, 8'd5 },  // R5 rewritten
        '{1'b1, AD0, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b1, T0,  1'b0, 8'd5 },  // R5 no eviction
        '{1'b1, AD2, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b1, T2,  1'b0, 8'd5 },
        '{1'b1, AD4, 1'b1, AD1, T1B, 1'b1, 1'b1, 1'b1, T4,  1'b0, 8'd9 },  // R9 correct
        '{1'b1, AD2, 1'b1, AD2, T2,  1'b0, 1'b1, 1'b0, Z,   1'b1, 8'd6 },  // R6 R10 bypass miss
        '{1'b1, AD2, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b0, Z,   1'b0, 8'd6 },  // R6 removed
        '{1'b0, Z,   1'b1, AD0, T0,  1'b0, 1'b0, 1'b0, Z,   1'b1, 8'd9 },  // R9 unhinted nt
        '{1'b1, AD0, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b1, T0,  1'b0, 8'd7 },  // R7 kept
        '{1'b0, Z,   1'b1, AD5, T5,  1'b1, 1'b0, 1'b0, Z,   1'b1, 8'd7 },
        '{1'b1, AD5, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b0, Z,   1'b0, 8'd7 },  // R7 not allocated
        '{1'b1, AD5, 1'b1, AD5, T5,  1'b1, 1'b0, 1'b0, Z,   1'b1, 8'd7 },  // R7 no bypass
        '{1'b0, Z,   1'b1, AD2, T2,  1'b1, 1'b1, 1'b0, Z,   1'b1, 8'd4 },  // R4 free way
        '{1'b1, AD4, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b1, T4,  1'b0, 8'd4 },  // R4 not evicted
        '{1'b1, AD2, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b1, T2,  1'b0, 8'd4 },
        '{1'b1, AD0, 1'b1, ADB, TB,  1'b1, 1'b1, 1'b1, T0,  1'b1, 8'd3 },  // R3 other set
        '{1'b1, ADB, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b1, TB,  1'b0, 8'd3 },
        '{1'b0, AD0, 1'b0, Z,   Z,   1'b0, 1'b0, 1'b0, Z,   1'b0, 8'd11}   // R11 idle
    };

    task automatic drive(input vec_t v);
        lk_valid   = v.lv;
        lk_addr    = v.la;
        upd_valid  = v.uv;
        upd_addr   = v.ua;
        upd_target = v.ut;
        upd_taken  = v.tk;
        upd_hint   = v.hn;
    endtask

    task automatic check(input vec_t v);
        bit ok;
        ok = (lk_hit === v.eh) && (lk_taken === v.eh) &&
             (!v.eh || lk_target === v.et) && (upd_mispredict === v.em);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: hit=%b taken=%b tgt=%h mis=%b, expected hit=%b tgt=%h mis=%b",
                     v.rq, lk_hit, lk_taken, lk_target, upd_mispredict, v.eh, v.et, v.em);
        end
    endtask

    function automatic vec_t lookup_only(logic [31:0] a, logic eh, logic [31:0] et, logic [7:0] rq);
        vec_t v;
        v    = '0;
        v.lv = 1'b1;
        v.la = a;
        v.eh = eh;
        v.et = et;
        v.rq = rq;
        return v;
    endfunction

    initial begin
        drive('0);
        repeat (3) @(posedge clk);
        #5;
        check('{default: '0, rq: 8'd1});   // R1 outputs quiet in reset
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #5;
            check(VECS[i]);
        end

        // R1: reset in mid-run clears every entry
        @(negedge clk);
        drive('0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(lookup_only(AD0, 1'b0, Z, 8'd1));
        #5;
        check(lookup_only(AD0, 1'b0, Z, 8'd1));
        @(negedge clk);
        drive(lookup_only(ADB, 1'b0, Z, 8'd1));
        #5;
        check(lookup_only(ADB, 1'b0, Z, 8'd1));
        // R2: word offset bits [1:0] are ignored by the lookup
        @(negedge clk);
        drive('{lv: 1'b0, la: Z, uv: 1'b1, ua: AD3, ut: T3, tk: 1'b1, hn: 1'b1,
                eh: 1'b0, et: Z, em: 1'b1, rq: 8'd4});
        @(negedge clk);
        drive(lookup_only(AD3 | 32'h3, 1'b1, T3, 8'd2));
        #5;
        check(lookup_only(AD3 | 32'h3, 1'b1, T3, 8'd2));
        @(negedge clk);
        drive('0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule